// File: doc/BRIEF.md
# Bus-written packet stream FIFO

This block lets a bus master build a packet stream one 32-bit word at a time. The master writes data words into a 16-entry FIFO through a small register slave. The FIFO head is presented on a ready/valid stream output with start-of-packet, end-of-packet and an empty-byte count. The packet flags do not travel on the same bus cycle as the data. The master first writes a metadata word, which stays pending inside the block. The pending flags are then attached to the next data word that the FIFO accepts, and the pending state clears once that word has taken them.

Before the first word of a packet, the master writes metadata with the start flag set. Before the final word, it writes metadata with the end flag and the number of unused bytes. A partial last word is packed from the most significant byte downward, and the block carries that word unaltered. The master can read back the fill level to throttle its writes. Three sticky event flags record the moment the FIFO drains to zero, a data write refused because the FIFO was full, and a forced pop from an empty FIFO. Any event whose enable bit is set raises the interrupt.

Top module: `pkt_push_fifo`

## Requirements
- R1: After synchronous reset, st_valid and irq are 0, and the level, event, enable and metadata registers all read 0.
- R2: A write to the data register (address 0) while fewer than 16 entries are held appends the word. Words leave the stream in write order, and the level register (address 2) reads the number of held entries, from 0 up to 16.
- R3: A write to the data register while 16 entries are held discards the word, leaves the level at 16, and sets event bit 1 (overflow).
- R4: A metadata write (address 1) stores a start flag from bit 0, an end flag from bit 1 and an empty count from bits 9:8. The next accepted data word carries these values on st_sop, st_eop and st_empty. The pending metadata then reads back as 0, so later words carry zeros.
- R5: A data write refused for overflow does not consume pending metadata. The metadata still reads back unchanged and attaches to the next accepted word.
- R6: A partial last word, for example one byte in bits 31:24 with empty 3, or three bytes in bits 31:8 with empty 1, appears on st_data bit for bit, together with the written empty count.
- R7: A force_pop pulse removes the head entry without needing st_ready. When the FIFO is empty, a force_pop leaves the level at 0 and sets event bit 2 (underflow).
- R8: Event bit 0 (drained) is set on the cycle the level falls from non-zero to zero.
- R9: The event register (address 3) is write-one-to-clear. Bits written as 0 keep their value.
- R10: irq is set one cycle after any event bit is set together with its bit in the enable register (address 4), and it falls one cycle after no such pair remains.
- R11: While st_valid is high, st_ready is low and force_pop is low, st_valid stays high and st_data, st_sop, st_eop and st_empty stay unchanged.
- R12: bus_rdata takes the selected register's value on the clock edge that samples bus_rd. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register select: 0 data, 1 metadata, 2 level, 3 events, 4 enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| st_valid | output | 1 | Stream word available |
| st_ready | input | 1 | Stream sink accepts the word |
| st_data | output | 32 | Stream word |
| st_sop | output | 1 | First word of a packet |
| st_eop | output | 1 | Last word of a packet |
| st_empty | output | 2 | Unused bytes in the last word |
| force_pop | input | 1 | Discard the head entry regardless of st_ready |
| irq | output | 1 | Registered interrupt |

## Verification
A wrong pointer or count in this block shows up as a word out of order, a duplicated word or a wrong level readback. The first such mismatch appears at the first pop or read after the corruption. A pending-metadata register that clears too early or too late shows as flags on the wrong word, at the next accepted data write. Event logic errors appear in the next event readback and, when that event is enabled, on irq one cycle later. The directed tests therefore compare every popped word with its flags, and read the level and event registers straight after each boundary: full, overflow, drain to zero and forced pop on empty.

// File: rtl/pkf_pkg.sv
package pkf_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_DATA  = 3'd0,
    REG_META  = 3'd1,
    REG_LEVEL = 3'd2,
    REG_EVENT = 3'd3,
    REG_IRQEN = 3'd4
  } pkf_reg_e;

  // event bit indices
  localparam int EV_DRAIN = 0;
  localparam int EV_OVF   = 1;
  localparam int EV_UNF   = 2;
  localparam int NUM_EV   = 3;

  // metadata word field positions
  localparam int META_SOP_BIT   = 0;
  localparam int META_EOP_BIT   = 1;
  localparam int META_EMPTY_LSB = 8;
endpackage

// File: rtl/pkf_meta_hold.sv
module pkf_meta_hold #(
  parameter int META_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [META_W-1:0] load_val,
  input  logic              consume,
  output logic [META_W-1:0] pending
);
  // holds flags until the next accepted data word takes them
  always_ff @(posedge clk) begin
    if (rst)          pending <= '0;
    else if (load)    pending <= load_val;
    else if (consume) pending <= '0;
  end
endmodule

// File: rtl/pkf_store.sv
module pkf_store #(
  parameter int ENTRY_W = 36,
  parameter int DEPTH   = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push_req,
  input  logic [ENTRY_W-1:0]            push_entry,
  input  logic                          ready_pop,
  input  logic                          force_pop,
  output logic [ENTRY_W-1:0]            head,
  output logic                          avail,
  output logic [$clog2(DEPTH+1)-1:0]    level,
  output logic                          push_ok,
  output logic                          overflow_hit,
  output logic                          underflow_hit,
  output logic                          drained
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   count, count_nx;
  logic               full, pop;

  assign full          = (count == CNT_W'(DEPTH));
  assign avail         = (count != '0);
  assign push_ok       = push_req && !full;
  assign overflow_hit  = push_req && full;
  assign pop           = avail && (ready_pop || force_pop);
  assign underflow_hit = force_pop && !avail;
  assign count_nx      = count + CNT_W'(push_ok) - CNT_W'(pop);
  assign drained       = avail && (count_nx == '0);
  assign level         = count;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_entry;
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop)     rd_ptr <= rd_ptr + 1'b1;
      count <= count_nx;
    end
  end
endmodule

// File: rtl/pkf_events.sv
module pkf_events #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic         en_wr,
  input  logic [N-1:0] en_val,
  output logic [N-1:0] events,
  output logic [N-1:0] enables,
  output logic         irq
);
  // one sticky flop per event; a new set wins over a same-cycle clear
  for (genvar i = 0; i < N; i++) begin : g_ev
    always_ff @(posedge clk) begin
      if (rst)                       events[i] <= 1'b0;
      else if (set_vec[i])           events[i] <= 1'b1;
      else if (clr_wr && clr_mask[i]) events[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enables <= '0;
      irq     <= 1'b0;
    end else begin
      if (en_wr) enables <= en_val;
      irq <= |(events & enables);
    end
  end
endmodule

// File: rtl/pkt_push_fifo.sv
module pkt_push_fifo
  import pkf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [REG_ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic                           st_valid,
  input  logic                           st_ready,
  output logic [DATA_W-1:0]              st_data,
  output logic                           st_sop,
  output logic                           st_eop,
  output logic [$clog2(DATA_W/8)-1:0]    st_empty,
  input  logic                           force_pop,
  output logic                           irq
);
  localparam int EMPTY_W = $clog2(DATA_W/8);
  localparam int META_W  = 2 + EMPTY_W;
  localparam int ENTRY_W = DATA_W + META_W;
  localparam int CNT_W   = $clog2(DEPTH+1);

  logic               wr_data, wr_meta, wr_event, wr_irqen;
  logic [META_W-1:0]  meta_in, meta_pend;
  logic [ENTRY_W-1:0] head;
  logic [CNT_W-1:0]   level_w;
  logic               push_ok, overflow_hit, underflow_hit, drained;
  logic [NUM_EV-1:0]  ev_set, ev_w, en_w;
  logic [DATA_W-1:0]  rd_mux;

  assign wr_data  = bus_wr && (bus_addr == REG_DATA);
  assign wr_meta  = bus_wr && (bus_addr == REG_META);
  assign wr_event = bus_wr && (bus_addr == REG_EVENT);
  assign wr_irqen = bus_wr && (bus_addr == REG_IRQEN);

  // pending metadata layout: {empty, eop, sop}
  assign meta_in = {bus_wdata[META_EMPTY_LSB +: EMPTY_W],
                    bus_wdata[META_EOP_BIT], bus_wdata[META_SOP_BIT]};

  pkf_meta_hold #(.META_W(META_W)) u_meta (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_meta),
    .load_val (meta_in),
    .consume  (push_ok),
    .pending  (meta_pend)
  );

  pkf_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_store (
    .clk           (clk),
    .rst           (rst),
    .push_req      (wr_data),
    .push_entry    ({meta_pend, bus_wdata}),
    .ready_pop     (st_ready),
    .force_pop     (force_pop),
    .head          (head),
    .avail         (st_valid),
    .level         (level_w),
    .push_ok       (push_ok),
    .overflow_hit  (overflow_hit),
    .underflow_hit (underflow_hit),
    .drained       (drained)
  );

  always_comb begin
    ev_set           = '0;
    ev_set[EV_DRAIN] = drained;
    ev_set[EV_OVF]   = overflow_hit;
    ev_set[EV_UNF]   = underflow_hit;
  end

  pkf_events #(.N(NUM_EV)) u_events (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (ev_set),
    .clr_wr   (wr_event),
    .clr_mask (bus_wdata[NUM_EV-1:0]),
    .en_wr    (wr_irqen),
    .en_val   (bus_wdata[NUM_EV-1:0]),
    .events   (ev_w),
    .enables  (en_w),
    .irq      (irq)
  );

  assign st_data  = head[DATA_W-1:0];
  assign st_sop   = head[DATA_W];
  assign st_eop   = head[DATA_W+1];
  assign st_empty = head[DATA_W+2 +: EMPTY_W];

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      REG_META: begin
        rd_mux[META_SOP_BIT]                = meta_pend[0];
        rd_mux[META_EOP_BIT]                = meta_pend[1];
        rd_mux[META_EMPTY_LSB +: EMPTY_W]   = meta_pend[2 +: EMPTY_W];
      end
      REG_LEVEL: rd_mux[CNT_W-1:0]  = level_w;
      REG_EVENT: rd_mux[NUM_EV-1:0] = ev_w;
      REG_IRQEN: rd_mux[NUM_EV-1:0] = en_w;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/pkt_push_fifo_chk.sv
module pkt_push_fifo_chk
  import pkf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         bus_wr,
  input logic [REG_ADDR_W-1:0]        bus_addr,
  input logic                         st_valid,
  input logic                         st_ready,
  input logic [DATA_W-1:0]            st_data,
  input logic                         st_sop,
  input logic                         st_eop,
  input logic [$clog2(DATA_W/8)-1:0]  st_empty,
  input logic                         force_pop,
  input logic                         irq,
  input logic [$clog2(DEPTH+1)-1:0]   level,
  input logic [NUM_EV-1:0]            ev,
  input logic [NUM_EV-1:0]            en
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic data_wr, popping;
  assign data_wr = bus_wr && (bus_addr == REG_DATA);
  assign popping = st_valid && (st_ready || force_pop);

  a_r2_level_max: assert property (@(posedge clk) disable iff (rst)
    level <= CNT_W'(DEPTH));

  a_r3_overflow_flag: assert property (@(posedge clk) disable iff (rst)
    (data_wr && level == CNT_W'(DEPTH)) |=> ev[EV_OVF]);

  a_r3_level_kept: assert property (@(posedge clk) disable iff (rst)
    (data_wr && level == CNT_W'(DEPTH) && !popping) |=> level == CNT_W'(DEPTH));

  a_r7_underflow_flag: assert property (@(posedge clk) disable iff (rst)
    (force_pop && level == '0) |=> (ev[EV_UNF] && level == '0));

  a_r8_drain_flag: assert property (@(posedge clk) disable iff (rst)
    (level == CNT_W'(1) && popping && !data_wr) |=> ev[EV_DRAIN]);

  a_r10_irq_follow: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(ev & en)));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready && !force_pop) |=>
      (st_valid && $stable(st_data) && $stable(st_sop) &&
       $stable(st_eop) && $stable(st_empty)));
endmodule

bind pkt_push_fifo pkt_push_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .st_data   (st_data),
  .st_sop    (st_sop),
  .st_eop    (st_eop),
  .st_empty  (st_empty),
  .force_pop (force_pop),
  .irq       (irq),
  .level     (level_w),
  .ev        (ev_w),
  .en        (en_w)
);

// File: tb/pkt_push_fifo_tb.sv
`timescale 1ns/1ps
module pkt_push_fifo_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        st_valid, st_ready = 1'b0;
  logic [31:0] st_data;
  logic        st_sop, st_eop;
  logic [1:0]  st_empty;
  logic        force_pop = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pkt_push_fifo u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
    .st_sop(st_sop), .st_eop(st_eop), .st_empty(st_empty),
    .force_pop(force_pop), .irq(irq)
  );

  localparam logic [2:0] A_DATA = 3'd0, A_META = 3'd1, A_LEVEL = 3'd2,
                         A_EVENT = 3'd3, A_IRQEN = 3'd4;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic pop_chk(input string req, input logic [31:0] d,
                         input logic s, input logic e, input logic [1:0] em);
    chk({req, " valid"}, {31'b0, st_valid}, 32'd1);
    chk({req, " data"}, st_data, d);
    chk({req, " flags"}, {28'b0, st_empty, st_eop, st_sop}, {28'b0, em, e, s});
    st_ready = 1'b1;
    @(negedge clk);
    st_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 valid", {31'b0, st_valid}, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    rd(A_LEVEL, v); chk("R1 level", v, 32'd0);
    rd(A_EVENT, v); chk("R1 events", v, 32'd0);
    rd(A_IRQEN, v); chk("R1 enables", v, 32'd0);
    rd(A_META, v);  chk("R1 meta", v, 32'd0);
  endtask

  task automatic t_order();
    logic [31:0] v;
    wr(A_DATA, 32'h1111_0001);
    wr(A_DATA, 32'h2222_0002);
    wr(A_DATA, 32'h3333_0003);
    rd(A_LEVEL, v); chk("R2 level 3", v, 32'd3);
    pop_chk("R2 w0", 32'h1111_0001, 0, 0, 2'd0);
    pop_chk("R2 w1", 32'h2222_0002, 0, 0, 2'd0);
    rd(A_LEVEL, v); chk("R2 level 1", v, 32'd1);
    pop_chk("R2 w2", 32'h3333_0003, 0, 0, 2'd0);
    chk("R2 empty", {31'b0, st_valid}, 32'd0);
    rd(A_EVENT, v); chk("R8 drained", v, 32'd1);
    wr(A_EVENT, 32'h7);
  endtask

  task automatic t_packet();
    logic [31:0] v;
    wr(A_META, 32'h0000_0001);
    rd(A_META, v); chk("R4 meta pending", v, 32'h1);
    wr(A_DATA, 32'hA0A0_A0A0);
    rd(A_META, v); chk("R4 meta cleared", v, 32'h0);
    wr(A_DATA, 32'hB0B0_B0B0);
    wr(A_META, 32'h0000_0302);
    wr(A_DATA, 32'hAB00_0000);
    wr(A_META, 32'h0000_0003);
    wr(A_DATA, 32'h1234_5678);
    wr(A_META, 32'h0000_0102);
    wr(A_DATA, 32'h1122_3300);
    repeat (3) @(negedge clk);
    chk("R11 held data", st_data, 32'hA0A0_A0A0);
    pop_chk("R4 sop word", 32'hA0A0_A0A0, 1, 0, 2'd0);
    pop_chk("R4 mid word", 32'hB0B0_B0B0, 0, 0, 2'd0);
    pop_chk("R6 one byte", 32'hAB00_0000, 0, 1, 2'd3);
    pop_chk("R4 single word pkt", 32'h1234_5678, 1, 1, 2'd0);
    pop_chk("R6 three bytes", 32'h1122_3300, 0, 1, 2'd1);
    wr(A_EVENT, 32'h7);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    for (int i = 0; i < 16; i++) wr(A_DATA, 32'hC000_0000 + i);
    rd(A_LEVEL, v); chk("R2 level full", v, 32'd16);
    wr(A_META, 32'h0000_0202);
    wr(A_DATA, 32'hDEAD_BEEF);
    rd(A_LEVEL, v); chk("R3 level stays 16", v, 32'd16);
    rd(A_EVENT, v); chk("R3 overflow event", v, 32'h2);
    rd(A_META, v);  chk("R5 meta kept", v, 32'h202);
    pop_chk("R3 head intact", 32'hC000_0000, 0, 0, 2'd0);
    wr(A_DATA, 32'h5A5A_5A00);
    rd(A_LEVEL, v); chk("R2 level refilled", v, 32'd16);
    for (int i = 1; i < 16; i++) pop_chk("R3 drain", 32'hC000_0000 + i, 0, 0, 2'd0);
    pop_chk("R5 meta attached", 32'h5A5A_5A00, 0, 1, 2'd2);
    rd(A_EVENT, v); chk("R8 overflow and drain", v, 32'h3);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(A_EVENT, 32'h2);
    rd(A_EVENT, v); chk("R9 clear ovf only", v, 32'h1);
    wr(A_EVENT, 32'h1);
    rd(A_EVENT, v); chk("R9 clear drain", v, 32'h0);
  endtask

  task automatic t_force();
    logic [31:0] v;
    force_pop = 1'b1; @(negedge clk); force_pop = 1'b0;
    rd(A_LEVEL, v); chk("R7 level after underflow", v, 32'd0);
    rd(A_EVENT, v); chk("R7 underflow event", v, 32'h4);
    wr(A_DATA, 32'h0000_00E1);
    wr(A_DATA, 32'h0000_00E2);
    force_pop = 1'b1; @(negedge clk); force_pop = 1'b0;
    chk("R7 head dropped", st_data, 32'h0000_00E2);
    rd(A_LEVEL, v); chk("R7 level 1", v, 32'd1);
    force_pop = 1'b1; @(negedge clk); force_pop = 1'b0;
    rd(A_EVENT, v); chk("R8 drain by force", v, 32'h5);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    @(negedge clk);
    chk("R10 irq off", {31'b0, irq}, 32'd0);
    wr(A_IRQEN, 32'h2);
    @(negedge clk);
    chk("R10 masked", {31'b0, irq}, 32'd0);
    wr(A_IRQEN, 32'h4);
    @(negedge clk);
    chk("R10 raised", {31'b0, irq}, 32'd1);
    wr(A_EVENT, 32'h4);
    @(negedge clk);
    chk("R10 lowered", {31'b0, irq}, 32'd0);
    rd(A_IRQEN, v); chk("R10 enable readback", v, 32'h4);
  endtask

  task automatic t_read_hold();
    logic [31:0] v;
    rd(A_EVENT, v); chk("R12 read value", v, 32'h1);
    wr(A_DATA, 32'h0000_0077);
    wr(A_EVENT, 32'h7);
    chk("R12 held", bus_rdata, 32'h1);
    rd(A_LEVEL, v); chk("R12 new read", v, 32'd1);
    pop_chk("R12 drain", 32'h0000_0077, 0, 0, 2'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_packet();
    t_overflow();
    t_w1c();
    t_force();
    t_irq();
    t_read_hold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule